// File: doc/BRIEF.md
# Byte-Addressed Control Register Slave on a Two-Wire Serial Bus

This block lets an external host read and write a bank of 32 eight-bit control and status registers over a two-wire serial bus (I2C fast mode, 400 kHz). Both bus pins are sampled from the system clock. Each pin passes through a synchronizer and a sliding-window majority filter, and start, repeated start and stop conditions are then detected from the filtered levels. The slave answers one of two 7-bit addresses, chosen by a strap pin. Its data output is a single open-drain pull-down enable.

A register pointer selects the register that is accessed. The first byte of a write transaction loads the pointer. Every byte written or read after that advances it by one. The pointer keeps its value across transactions, so a read that does not first set the pointer continues from where the last access stopped.

The register bank has these parts:
- An identification byte.
- A live copy of an 8-bit hardware status input.
- An event flag register. Its bits are set by pulses and cleared when the register is read.
- A mask register that gates the flags onto an interrupt request.
- A soft-reset register. Writing it restores the register bank to its reset values.

All register contents are driven out in parallel to the logic that uses them.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, the register values are: 0x09 at 0x00, 0x98 at 0x04, 0x18 at 0x05, 0x01 at each of 0x08 to 0x0C, 0x08 at 0x12, and 0x00 everywhere else (0x03 follows status_i). After reset, irq_o is low and sda_oe_o is low. On regs_o, register n occupies bits [8n+7:8n].
- R2: The slave address is {ADDR_BASE[6:1], addr_sel_i}. With the default base this gives 0x42 or 0x43. An address byte is its 7 bits followed by R/W (0 = write). The slave acknowledges a matching address by driving SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the rest of the transaction.
- R3: In a write transaction, the first byte after the address loads the pointer. Each following byte is stored at the pointer, and the pointer then increments. Every byte is acknowledged.
- R4: In a read transaction, bytes are sent MSB first, starting at the pointer. The pointer increments after each byte is loaded. The slave keeps sending while the master acknowledges. After a NACK it releases SDA and waits for a start or stop.
- R5: A write of the pointer followed by a repeated start and a read address begins the read at that pointer.
- R6: The pointer is kept between transactions. A read without a pointer write continues from the last position. The pointer is 8 bits and wraps from 0xFF to 0x00.
- R7: Writes to 0x00, 0x02, 0x03 or any address at or above 0x20 are acknowledged and discarded. Reads of addresses at or above 0x20 return 0x00.
- R8: Register 0x03 holds the value of status_i from the previous clock.
- R9: A high bit on event_i sets the same bit of register 0x02. The bit stays set until register 0x02 is loaded for transmission, which returns the current value and clears it. A read that ends with a NACK before reaching 0x02 leaves the flags intact.
- R10: irq_o is high exactly when some bit of 0x02 is set and the same bit of the mask register 0x01 is 0.
- R11: Writing 0x1E with bit 0 = 1 restores every writable register to its R1 value and clears 0x02. The pointer is unaffected. Writing 0x1E with bit 0 = 0 has no effect. Register 0x1E always reads 0x00.
- R12: A pulse on SCL or SDA of FILT_WIN/2 system clocks or fewer is ignored. With the defaults this is 10 clocks, which is 50 ns at 200 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level |
| addr_sel_i | input | 1 | Selects the low bit of the slave address |
| status_i | input | 8 | Hardware status, mirrored in register 0x03 |
| event_i | input | 8 | Event pulses that set the flag bits in 0x02 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| regs_o | output | 256 | All 32 registers, register n at [8n+7:8n] |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench goes after the corner cases below. Each one names the failure a broken design would show.

- **Pointer reuse.** A pointerless read continues after a combined read, a plain write, and a wrap through 0xFF. A pointer reset at stop would instead return register 0x00.
- **Flag clearing.** Flags are read both directly and after a NACKed read of the neighbouring mask register. A design that prefetches the next byte before the master's acknowledge would clear flags the host never saw.
- **Soft reset.** Register 0x1E is written with bit 0 clear and then set. This exposes a reset that acts on any write, or one that also clears the pointer.
- **Glitch rejection.** SCL and SDA are pulsed for eight clocks while SCL is high. A weak filter would count extra bits, or detect a false stop or start in the middle of a byte.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_REGS = 32;
    localparam int PTR_W    = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam int unsigned ADDR_ID   = 0;
    localparam int unsigned ADDR_MASK = 1;
    localparam int unsigned ADDR_FLAG = 2;
    localparam int unsigned ADDR_STAT = 3;
    localparam int unsigned ADDR_SRST = 30;

    typedef enum logic [2:0] {
        RK_RW,
        RK_ID,
        RK_FLAG,
        RK_STAT,
        RK_SRST
    } reg_kind_e;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_RX,
        LK_RX_ACK,
        LK_TX,
        LK_TX_ACK
    } link_state_e;

    function automatic reg_kind_e kind_of(input int unsigned a);
        case (a)
            ADDR_ID:   return RK_ID;
            ADDR_FLAG: return RK_FLAG;
            ADDR_STAT: return RK_STAT;
            ADDR_SRST: return RK_SRST;
            default:   return RK_RW;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] reset_value(input int unsigned a);
        if (a == ADDR_ID)           return 8'h09;
        if (a == 4)                 return 8'h98;
        if (a == 5)                 return 8'h18;
        if (a >= 8 && a <= 12)      return 8'h01;
        if (a == 18)                return 8'h08;
        return '0;
    endfunction

endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int WIN         = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    localparam int HALF  = WIN / 2;
    localparam int CNT_W = $clog2(WIN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [WIN-1:0]         win;
        logic                   out;
    } filt_t;

    filt_t q, d;
    logic [CNT_W-1:0] ones;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], pin_i};
        d.win  = {q.win[WIN-2:0], q.sync[SYNC_STAGES-1]};
        ones   = '0;
        for (int i = 0; i < WIN; i++) begin
            ones = ones + CNT_W'(q.win[i]);
        end
        d.out  = (ones > CNT_W'(HALF));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: '1, win: '1, out: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign pin_o = q.out;

    // A single-cycle dip in the window never flips a settled output (R12)
    p_short_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.out && (&q.win[WIN-2:0])) |=> q.out);

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm import i2c_regbank_pkg::*; #(
    parameter logic [6:0] ADDR_BASE = 7'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f_i,
    input  logic              sda_f_i,
    input  logic              addr_sel_i,
    input  logic [REG_W-1:0]  rd_data_i,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [REG_W-1:0]  wr_data_o,
    output logic              rd_en_o,
    output logic [PTR_W-1:0]  rd_addr_o,
    output logic              sda_oe_o
);
    typedef struct packed {
        link_state_e       st;
        logic [3:0]        bits;
        logic [REG_W-1:0]  sh;
        logic [PTR_W-1:0]  ptr;
        logic              rw;
        logic              have_ptr;
        logic              mack;
        logic              oe;
        logic              scl_p;
        logic              sda_p;
    } link_t;

    link_t q, d;
    logic  scl_rise, scl_fall, start_det, stop_det, do_load;
    logic [6:0] my_addr;

    assign my_addr   = {ADDR_BASE[6:1], addr_sel_i};
    assign scl_rise  = scl_f_i & ~q.scl_p;
    assign scl_fall  = ~scl_f_i & q.scl_p;
    assign start_det = scl_f_i & q.scl_p & q.sda_p & ~sda_f_i;
    assign stop_det  = scl_f_i & q.scl_p & ~q.sda_p & sda_f_i;

    always_comb begin
        d         = q;
        d.scl_p   = scl_f_i;
        d.sda_p   = sda_f_i;
        wr_en_o   = 1'b0;
        wr_addr_o = q.ptr;
        wr_data_o = q.sh;
        rd_en_o   = 1'b0;
        do_load   = 1'b0;

        case (q.st)
            LK_ADDR: begin
                if (scl_rise) begin
                    d.sh   = {q.sh[REG_W-2:0], sda_f_i};
                    d.bits = q.bits + 4'd1;
                end else if (scl_fall && q.bits == 4'd8) begin
                    if (q.sh[7:1] == my_addr) begin
                        d.st = LK_ADDR_ACK;
                        d.oe = 1'b1;
                        d.rw = q.sh[0];
                    end else begin
                        d.st = LK_IDLE;
                    end
                end
            end
            LK_ADDR_ACK: begin
                if (scl_fall) begin
                    if (q.rw) begin
                        do_load = 1'b1;
                    end else begin
                        d.oe   = 1'b0;
                        d.st   = LK_RX;
                        d.bits = '0;
                    end
                end
            end
            LK_RX: begin
                if (scl_rise) begin
                    d.sh   = {q.sh[REG_W-2:0], sda_f_i};
                    d.bits = q.bits + 4'd1;
                end else if (scl_fall && q.bits == 4'd8) begin
                    d.oe = 1'b1;
                    d.st = LK_RX_ACK;
                    if (!q.have_ptr) begin
                        d.ptr      = q.sh;
                        d.have_ptr = 1'b1;
                    end else begin
                        wr_en_o = 1'b1;
                        d.ptr   = q.ptr + 1'b1;
                    end
                end
            end
            LK_RX_ACK: begin
                if (scl_fall) begin
                    d.oe   = 1'b0;
                    d.st   = LK_RX;
                    d.bits = '0;
                end
            end
            LK_TX: begin
                if (scl_fall) begin
                    d.bits = q.bits + 4'd1;
                    if (q.bits == 4'd7) begin
                        d.oe = 1'b0;
                        d.st = LK_TX_ACK;
                    end else begin
                        d.sh = {q.sh[REG_W-2:0], 1'b0};
                        d.oe = ~q.sh[REG_W-2];
                    end
                end
            end
            LK_TX_ACK: begin
                if (scl_rise) begin
                    d.mack = sda_f_i;
                end else if (scl_fall) begin
                    if (!q.mack) begin
                        do_load = 1'b1;
                    end else begin
                        d.st = LK_IDLE;
                    end
                end
            end
            default: ;
        endcase

        if (do_load) begin
            rd_en_o = 1'b1;
            d.sh    = rd_data_i;
            d.ptr   = q.ptr + 1'b1;
            d.oe    = ~rd_data_i[REG_W-1];
            d.bits  = '0;
            d.st    = LK_TX;
        end

        if (start_det) begin
            d.st       = LK_ADDR;
            d.bits     = '0;
            d.oe       = 1'b0;
            d.have_ptr = 1'b0;
        end else if (stop_det) begin
            d.st = LK_IDLE;
            d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: LK_IDLE, bits: '0, sh: '0, ptr: '0, rw: 1'b0,
                   have_ptr: 1'b0, mack: 1'b1, oe: 1'b0, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o = q.ptr;
    assign sda_oe_o  = q.oe;

    p_ptr_step_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (q.ptr == $past(q.ptr) + 1'b1));

    p_ptr_step_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> (q.ptr == $past(q.ptr) + 1'b1));

    p_drive_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_f_i);

    p_release_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !q.oe);

endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store import i2c_regbank_pkg::*; (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [PTR_W-1:0]          wr_addr_i,
    input  logic [REG_W-1:0]          wr_data_i,
    input  logic                      rd_en_i,
    input  logic [PTR_W-1:0]          rd_addr_i,
    output logic [REG_W-1:0]          rd_data_o,
    input  logic [REG_W-1:0]          status_i,
    input  logic [REG_W-1:0]          event_i,
    output logic [NUM_REGS*REG_W-1:0] regs_o,
    output logic                      irq_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] r;
    } bank_t;

    bank_t q, d;
    logic  srst, wr_hit, rd_flag;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    assign wr_idx  = wr_addr_i[IDX_W-1:0];
    assign rd_idx  = rd_addr_i[IDX_W-1:0];
    assign wr_hit  = wr_en_i && (int'(wr_addr_i) < NUM_REGS)
                     && (kind_of(int'(wr_addr_i)) == RK_RW);
    assign srst    = wr_en_i && (int'(wr_addr_i) == ADDR_SRST) && wr_data_i[0];
    assign rd_flag = rd_en_i && (int'(rd_addr_i) == ADDR_FLAG);

    always_comb begin
        d = q;
        d.r[ADDR_STAT] = status_i;
        if (rd_flag) begin
            d.r[ADDR_FLAG] = '0;
        end
        if (wr_hit) begin
            d.r[wr_idx] = wr_data_i;
        end
        if (srst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (kind_of(i) == RK_RW) begin
                    d.r[i] = reset_value(i);
                end
            end
            d.r[ADDR_FLAG] = '0;
        end
        d.r[ADDR_FLAG] = d.r[ADDR_FLAG] | event_i;
    end

    always_comb begin
        rd_data_o = '0;
        if (int'(rd_addr_i) < NUM_REGS && kind_of(int'(rd_addr_i)) != RK_SRST) begin
            rd_data_o = q.r[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                q.r[i] <= reset_value(i);
            end
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[g*REG_W +: REG_W] = q.r[g];
    end

    assign irq_o = |(q.r[ADDR_FLAG] & ~q.r[ADDR_MASK]);

    p_srst_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (q.r[ADDR_MASK] == 8'h00 && q.r[4] == 8'h98 && q.r[18] == 8'h08));

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag && event_i == '0) |=> (q.r[ADDR_FLAG] == '0));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_flag && !srst) |=>
            ((q.r[ADDR_FLAG] & $past(q.r[ADDR_FLAG])) == $past(q.r[ADDR_FLAG])));

    p_id_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(wr_addr_i) == ADDR_ID) |=> $stable(q.r[ADDR_ID]));

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave import i2c_regbank_pkg::*; #(
    parameter logic [6:0] ADDR_BASE   = 7'h42,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_WIN    = 21
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    input  logic                      addr_sel_i,
    input  logic [REG_W-1:0]          status_i,
    input  logic [REG_W-1:0]          event_i,
    output logic                      sda_oe_o,
    output logic [NUM_REGS*REG_W-1:0] regs_o,
    output logic                      irq_o
);
    logic             scl_f, sda_f;
    logic             wr_en, rd_en;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic [REG_W-1:0] wr_data, rd_data;

    i2c_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .WIN(FILT_WIN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .pin_i(scl_i), .pin_o(scl_f));

    i2c_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .WIN(FILT_WIN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .pin_i(sda_i), .pin_o(sda_f));

    i2c_link_fsm #(.ADDR_BASE(ADDR_BASE)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_f_i(scl_f), .sda_f_i(sda_f),
        .addr_sel_i(addr_sel_i), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .sda_oe_o(sda_oe_o));

    i2c_reg_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .status_i(status_i), .event_i(event_i),
        .regs_o(regs_o), .irq_o(irq_o));

endmodule

// File: tb/i2c_regbank_slave_bench.sv
`timescale 1ns/1ps
module i2c_regbank_slave_bench;
    localparam int Q  = 30;
    localparam int GW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, scl_g = 1'b0, sda_g = 1'b0;
    logic addr_sel = 1'b0;
    logic [7:0] status = 8'h00, events = 8'h00;
    logic sda_oe, irq;
    logic [255:0] regs;
    logic scl_line, sda_line;

    int n_vec = 0, n_bad = 0;
    bit settled = 0;
    int glitch_mode = 0;
    logic [7:0] mregs [32];
    logic [7:0] mptr = 8'h00;

    always #2.5 clk = ~clk;

    assign scl_line = scl_m ^ scl_g;
    assign sda_line = (sda_m & ~sda_oe) ^ sda_g;

    i2c_regbank_slave u_i2c_regbank_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .status_i(status), .event_i(events),
        .sda_oe_o(sda_oe), .regs_o(regs), .irq_o(irq));

    function automatic logic [7:0] rv(input int a);
        if (a == 0) return 8'h09;
        if (a == 4) return 8'h98;
        if (a == 5) return 8'h18;
        if (a >= 8 && a <= 12) return 8'h01;
        if (a == 18) return 8'h08;
        return 8'h00;
    endfunction

    function automatic bit writable(input int a);
        return a < 32 && a != 0 && a != 2 && a != 3 && a != 30;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // per-clock comparison against the behavioural register model
    always @(negedge clk) begin
        if (settled && rst_n) begin
            logic bad;
            logic exp_irq;
            bad = 0;
            n_vec++;
            for (int i = 0; i < 32; i++) begin
                if (regs[i*8 +: 8] !== mregs[i]) begin
                    if (!bad) $display("FAIL state R1,R3,R7,R9,R11 reg%0h actual=%0h expected=%0h",
                                       i, regs[i*8 +: 8], mregs[i]);
                    bad = 1;
                end
            end
            exp_irq = |(mregs[2] & ~mregs[1]);
            if (irq !== exp_irq) begin
                $display("FAIL R10 irq actual=%0b expected=%0b", irq, exp_irq);
                bad = 1;
            end
            if (bad) n_bad++;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b, output logic r);
        sda_m = b;
        wait_clk(Q);
        scl_m = 1'b1;
        wait_clk(6);
        if (glitch_mode == 1) scl_g = 1'b1;
        if (glitch_mode == 2) sda_g = 1'b1;
        wait_clk(GW);
        scl_g = 1'b0;
        sda_g = 1'b0;
        wait_clk(Q - 6 - GW);
        r = sda_line;
        wait_clk(Q);
        scl_m = 1'b0;
        wait_clk(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) put_bit(b[i], r);
        put_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, r);
            b[i] = r;
        end
        put_bit(nack, r);
    endtask

    task automatic m_write(input logic [7:0] b);
        if (mptr == 8'd30 && b[0]) begin
            for (int i = 0; i < 32; i++) if (writable(i)) mregs[i] = rv(i);
            mregs[2] = 8'h00;
        end else if (writable(int'(mptr))) begin
            mregs[mptr[4:0]] = b;
        end
        mptr = mptr + 8'd1;
    endtask

    function automatic logic [7:0] m_read();
        logic [7:0] v;
        v = (mptr < 8'd32 && mptr != 8'd30) ? mregs[mptr[4:0]] : 8'h00;
        if (mptr == 8'd2) mregs[2] = 8'h00;
        mptr = mptr + 8'd1;
        return v;
    endfunction

    task automatic settle();
        wait_clk(40);
        settled = 1;
    endtask

    task automatic wr_xfer(input logic [6:0] dev, input logic [7:0] ptr,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                           input int n, input logic exp_ack, input string req);
        logic ack;
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        settled = 0;
        bus_start();
        send_byte({dev, 1'b0}, ack);
        chk({req, " address ack"}, 32'(ack), 32'(exp_ack));
        send_byte(ptr, ack);
        if (exp_ack) begin
            chk({req, " pointer ack"}, 32'(ack), 32'd1);
            mptr = ptr;
        end
        for (int i = 0; i < n; i++) begin
            send_byte(dv[i], ack);
            if (exp_ack) begin
                chk({req, " data ack"}, 32'(ack), 32'd1);
                m_write(dv[i]);
            end else begin
                chk({req, " data ignored"}, 32'(ack), 32'd0);
            end
        end
        bus_stop();
        settle();
    endtask

    task automatic rd_xfer(input logic [6:0] dev, input bit set_ptr, input logic [7:0] ptr,
                           input int n, input string req);
        logic ack;
        logic [7:0] b, e;
        settled = 0;
        bus_start();
        if (set_ptr) begin
            send_byte({dev, 1'b0}, ack);
            send_byte(ptr, ack);
            mptr = ptr;
            bus_start();
        end
        send_byte({dev, 1'b1}, ack);
        chk({req, " read address ack"}, 32'(ack), 32'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            e = m_read();
            chk({req, " read data"}, 32'(b), 32'(e));
        end
        wait_clk(2);
        chk({req, " SDA released after NACK"}, 32'(sda_oe), 32'd0);
        bus_stop();
        settle();
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mregs[i] = rv(i);
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R1 reg00", 32'(regs[0 +: 8]), 32'h09);
        chk("R1 reg04", 32'(regs[32 +: 8]), 32'h98);
        chk("R1 reg05", 32'(regs[40 +: 8]), 32'h18);
        chk("R1 reg0C", 32'(regs[96 +: 8]), 32'h01);
        chk("R1 reg12", 32'(regs[144 +: 8]), 32'h08);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 sda", 32'(sda_oe), 32'd0);
        settle();

        // R2: wrong address ignored, then select pin moves the address
        wr_xfer(7'h44, 8'h04, 8'hEE, 8'h00, 8'h00, 1, 1'b0, "R2 mismatch");
        addr_sel = 1'b1;
        wr_xfer(7'h42, 8'h04, 8'hEE, 8'h00, 8'h00, 1, 1'b0, "R2 sel1 rejects 42");
        wr_xfer(7'h43, 8'h13, 8'h6B, 8'h00, 8'h00, 1, 1'b1, "R2 sel1 accepts 43");
        addr_sel = 1'b0;

        // R3 burst write, R5 combined read, R6 pointer retained
        wr_xfer(7'h42, 8'h04, 8'hA5, 8'h5A, 8'h3C, 3, 1'b1, "R3 burst");
        rd_xfer(7'h42, 1, 8'h04, 3, "R5 combined R4");
        rd_xfer(7'h42, 0, 8'h00, 2, "R6 continue after read");
        wr_xfer(7'h42, 8'h0D, 8'h11, 8'h00, 8'h00, 1, 1'b1, "R3 single");
        rd_xfer(7'h42, 0, 8'h00, 1, "R6 continue after write");

        // R7 read-only and unimplemented space, R6 wrap
        wr_xfer(7'h42, 8'h00, 8'h55, 8'h66, 8'h77, 3, 1'b1, "R7 ro writes");
        wr_xfer(7'h42, 8'h20, 8'hAB, 8'h00, 8'h00, 1, 1'b1, "R7 unimplemented write");
        rd_xfer(7'h42, 1, 8'h1F, 3, "R7 unimplemented read");
        rd_xfer(7'h42, 1, 8'hFF, 2, "R6 wrap");

        // R8 live status
        settled = 0; status = 8'hC3; mregs[3] = 8'hC3; wait_clk(3); settled = 1;
        rd_xfer(7'h42, 1, 8'h03, 1, "R8 status");

        // R9, R10 flags and mask
        wr_xfer(7'h42, 8'h01, 8'h01, 8'h00, 8'h00, 1, 1'b1, "R10 mask set");
        settled = 0;
        events = 8'h21; wait_clk(1); events = 8'h00;
        mregs[2] = mregs[2] | 8'h21;
        wait_clk(3); settled = 1;
        wait_clk(2);
        chk("R10 irq unmasked bit", 32'(irq), 32'd1);
        wr_xfer(7'h42, 8'h01, 8'h21, 8'h00, 8'h00, 1, 1'b1, "R10 mask all");
        chk("R10 irq masked", 32'(irq), 32'd0);
        wr_xfer(7'h42, 8'h01, 8'h00, 8'h00, 8'h00, 1, 1'b1, "R10 mask clear");
        chk("R10 irq raised", 32'(irq), 32'd1);
        rd_xfer(7'h42, 1, 8'h01, 1, "R9 nack before flags");
        chk("R9 flags kept", 32'(regs[16 +: 8]), 32'h21);
        rd_xfer(7'h42, 0, 8'h00, 1, "R9 read clears");
        chk("R9 flags cleared", 32'(regs[16 +: 8]), 32'h00);
        chk("R10 irq after clear", 32'(irq), 32'd0);

        // R11 soft reset
        wr_xfer(7'h42, 8'h1E, 8'h00, 8'h00, 8'h00, 1, 1'b1, "R11 bit0 clear");
        chk("R11 no effect", 32'(regs[32 +: 8]), 32'hA5);
        settled = 0;
        events = 8'h04; wait_clk(1); events = 8'h00;
        mregs[2] = mregs[2] | 8'h04;
        wait_clk(3); settled = 1;
        wr_xfer(7'h42, 8'h1E, 8'h01, 8'h00, 8'h00, 1, 1'b1, "R11 reset");
        chk("R11 reg04 restored", 32'(regs[32 +: 8]), 32'h98);
        chk("R11 flags cleared", 32'(regs[16 +: 8]), 32'h00);
        rd_xfer(7'h42, 0, 8'h00, 2, "R11 pointer kept");

        // R12 glitches on SCL and on SDA
        glitch_mode = 1;
        wr_xfer(7'h42, 8'h0E, 8'h77, 8'h88, 8'h00, 2, 1'b1, "R12 scl glitch");
        glitch_mode = 2;
        wr_xfer(7'h42, 8'h10, 8'hC5, 8'h00, 8'h00, 1, 1'b1, "R12 sda glitch");
        glitch_mode = 0;
        rd_xfer(7'h42, 1, 8'h0E, 3, "R12 readback");

        wait_clk(20);
        summary();
    end
endmodule